// File: doc/BRIEF.md
# TRS Word Framing Controller

This block recovers word alignment for a 10-bit video word stream that has been parallelized from a bit-serial source at an unknown bit offset. Each cycle it joins the two most recent raw words into a 20-bit window and inspects all ten candidate offsets at once. A timing reference sequence (three preamble words followed by a status word) found at one of those offsets may move the alignment boundary. Whether it does depends on a realignment policy chosen by two control inputs.

The block outputs the word taken at the current boundary and a one-cycle strobe for every sequence it decodes. It also outputs the field, vertical-blanking and horizontal-blanking flags from the most recent status word, and a status bit. That status bit reports a sequence seen off the current boundary that was not acted on. Policies: hold the first boundary found; follow every sequence; or move only when an off-boundary sequence repeats after having been flagged, which gives the same behaviour as wiring the status bit back into the enable.

Top module: `trs_framer`

## Requirements
- R1: After synchronous reset the outputs `word_out`, `trs_stb`, `h_flag`, `v_flag`, `f_flag` and `nsp` are all 0. The boundary offset is 0 and the block is unlocked.
- R2: With the raw bits numbered so that bit j of raw word n is stream bit 10n+j, the candidate word at offset k (0..9) is stream bits 10(n-1)+k to 10(n-1)+k+9 (LSB first). A valid sequence is, at one offset k, the candidate words 3FF, 000, 000 in three consecutive cycles, followed by a status word whose bit 9 is 1. `trs_stb` is high for one cycle, 3 cycles after the raw word that completes the status word is presented.
- R3: A sequence whose status word has bit 9 clear is ignored: no strobe, and no change to the boundary, the flags or `nsp`.
- R4: `word_out`, 3 cycles after raw word n is presented, equals stream bits 10(n-1)+b to 10(n-1)+b+9, where b is the boundary offset in force at that time.
- R5: While unlocked, the first valid sequence sets the boundary to its offset in every policy and locks the block. The new offset applies from the word after the status word.
- R6: With `frm_mode`=0 and `frm_enable`=0, a valid sequence off the current boundary leaves the boundary unchanged and sets `nsp`.
- R7: A valid sequence on the current boundary clears `nsp` in every policy.
- R8: With `frm_mode`=0 and `frm_enable`=1, every valid sequence moves the boundary to its offset, and `nsp` stays 0.
- R9: With `frm_mode`=1, `frm_enable` is ignored. An off-boundary sequence sets `nsp` and holds the boundary when `nsp` is clear. It moves the boundary and clears `nsp` when `nsp` is already set.
- R10: `f_flag`, `v_flag` and `h_flag` take bits 8, 7 and 6 of a valid status word (active high). They change only in the cycle `trs_stb` is high and hold otherwise.
- R11: `nsp` changes only in a cycle where `trs_stb` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| raw_in | input | 10 | Unaligned parallel word, LSB is the earliest bit |
| frm_mode | input | 1 | Selects the flag-then-realign policy |
| frm_enable | input | 1 | With `frm_mode` clear, realign on every sequence |
| word_out | output | 10 | Word at the current boundary |
| trs_stb | output | 1 | One-cycle pulse per decoded sequence |
| h_flag | output | 1 | Horizontal blanking flag from the last status word |
| v_flag | output | 1 | Vertical blanking flag from the last status word |
| f_flag | output | 1 | Field flag from the last status word |
| nsp | output | 1 | Sequence seen off the current boundary |

## Verification
Every result of this block is due exactly 3 cycles after the raw word that produced it: the aligned word, the strobe, and the flag and `nsp` updates that share the strobe cycle. A boundary change first shows on the word that follows the status word. The bench builds each stream at bit level and runs a cycle-by-cycle model of the policy, indexed by detection cycle. It offsets every expected value by those two pipeline stages before comparing. It samples on the falling edge, so the word, the strobe, the flags and `nsp` are all compared once per cycle, and a result that arrives one cycle early or late is reported.

// File: rtl/trs_pkg.sv
package trs_pkg;
    localparam int WORD_W   = 10;
    localparam int OFF_W    = $clog2(WORD_W);
    localparam int MARK_BIT = WORD_W - 1;

    typedef logic [WORD_W-1:0]   word_t;
    typedef logic [OFF_W-1:0]    off_t;
    typedef logic [2*WORD_W-1:0] pair_t;

    typedef struct packed {
        logic f;
        logic v;
        logic h;
    } fvh_t;

    typedef struct packed {
        word_t word;
        logic  stb;
        fvh_t  fvh;
    } stage_t;

    typedef enum logic [1:0] {
        POL_HOLD,
        POL_EVERY,
        POL_FLAGGED
    } policy_e;

    localparam word_t PRE_ONES = '1;
    localparam word_t PRE_ZERO = '0;

    function automatic word_t slice_at(pair_t p, off_t k);
        pair_t s;
        s = p >> k;
        return s[WORD_W-1:0];
    endfunction

    function automatic fvh_t fvh_of(word_t w);
        fvh_t r;
        r.f = w[8];
        r.v = w[7];
        r.h = w[6];
        return r;
    endfunction

    function automatic policy_e policy_of(logic mode, logic en);
        if (mode)
            return POL_FLAGGED;
        else if (en)
            return POL_EVERY;
        else
            return POL_HOLD;
    endfunction
endpackage

// File: rtl/trs_search.sv
module trs_search
    import trs_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  pair_t win,
    output logic  hit,
    output off_t  hit_off,
    output word_t hit_word
);
    word_t             cand [WORD_W];
    logic [WORD_W-1:0] hit_vec;

    generate
        for (genvar k = 0; k < WORD_W; k++) begin : g_lane
            logic saw1, saw2, saw3;
            assign cand[k] = slice_at(win, off_t'(k));
            always_ff @(posedge clk) begin
                if (rst) begin
                    saw1 <= 1'b0;
                    saw2 <= 1'b0;
                    saw3 <= 1'b0;
                end else begin
                    saw1 <= (cand[k] == PRE_ONES);
                    saw2 <= saw1 && (cand[k] == PRE_ZERO);
                    saw3 <= saw2 && (cand[k] == PRE_ZERO);
                end
            end
            assign hit_vec[k] = saw3 && cand[k][MARK_BIT];
        end
    endgenerate

    // lowest offset wins if several lanes complete together
    always_comb begin
        hit_off = '0;
        for (int i = WORD_W - 1; i >= 0; i--) begin
            if (hit_vec[i]) hit_off = off_t'(i);
        end
    end

    assign hit      = |hit_vec;
    assign hit_word = cand[hit_off];
endmodule

// File: rtl/trs_policy.sv
module trs_policy
    import trs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic hit,
    input  off_t hit_off,
    input  logic frm_mode,
    input  logic frm_enable,
    output off_t cur_off,
    output logic locked,
    output logic nsp_r
);
    policy_e pol;
    assign pol = policy_of(frm_mode, frm_enable);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_off <= '0;
            locked  <= 1'b0;
            nsp_r   <= 1'b0;
        end else if (hit) begin
            if (!locked) begin
                cur_off <= hit_off;
                locked  <= 1'b1;
                nsp_r   <= 1'b0;
            end else if (hit_off == cur_off) begin
                nsp_r <= 1'b0;
            end else begin
                case (pol)
                    POL_EVERY: begin
                        cur_off <= hit_off;
                        nsp_r   <= 1'b0;
                    end
                    POL_FLAGGED: begin
                        if (nsp_r) begin
                            cur_off <= hit_off;
                            nsp_r   <= 1'b0;
                        end else begin
                            nsp_r <= 1'b1;
                        end
                    end
                    default: nsp_r <= 1'b1;
                endcase
            end
        end
    end
endmodule

// File: rtl/trs_framer.sv
module trs_framer
    import trs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] raw_in,
    input  logic              frm_mode,
    input  logic              frm_enable,
    output logic [WORD_W-1:0] word_out,
    output logic              trs_stb,
    output logic              h_flag,
    output logic              v_flag,
    output logic              f_flag,
    output logic              nsp
);
    word_t  raw_q, raw_qq;
    pair_t  win;
    logic   hit;
    off_t   hit_off;
    word_t  hit_word;
    off_t   cur_off;
    logic   locked;
    logic   nsp_r;
    stage_t sa;
    fvh_t   fvh_o;

    assign win = {raw_q, raw_qq};

    trs_search u_search (
        .clk      (clk),
        .rst      (rst),
        .win      (win),
        .hit      (hit),
        .hit_off  (hit_off),
        .hit_word (hit_word)
    );

    trs_policy u_policy (
        .clk        (clk),
        .rst        (rst),
        .hit        (hit),
        .hit_off    (hit_off),
        .frm_mode   (frm_mode),
        .frm_enable (frm_enable),
        .cur_off    (cur_off),
        .locked     (locked),
        .nsp_r      (nsp_r)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_q    <= '0;
            raw_qq   <= '0;
            sa       <= '0;
            word_out <= '0;
            trs_stb  <= 1'b0;
            fvh_o    <= '0;
            nsp      <= 1'b0;
        end else begin
            raw_q    <= raw_in;
            raw_qq   <= raw_q;
            sa.word  <= slice_at(win, cur_off);
            sa.stb   <= hit;
            sa.fvh   <= fvh_of(hit_word);
            word_out <= sa.word;
            trs_stb  <= sa.stb;
            nsp      <= nsp_r;
            if (sa.stb) fvh_o <= sa.fvh;
        end
    end

    assign f_flag = fvh_o.f;
    assign v_flag = fvh_o.v;
    assign h_flag = fvh_o.h;
endmodule

// File: rtl/trs_framer_chk.sv
module trs_framer_chk
    import trs_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic frm_mode,
    input logic frm_enable,
    input logic trs_stb,
    input logic h_flag,
    input logic v_flag,
    input logic f_flag,
    input logic nsp,
    input logic hit,
    input off_t hit_off,
    input off_t cur_off,
    input logic locked,
    input logic nsp_r
);
    // R10
    flags_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !trs_stb |=> (trs_stb || $stable({f_flag, v_flag, h_flag})));

    // R11
    nsp_edge_chk: assert property (@(posedge clk) disable iff (rst)
        !trs_stb |-> $stable(nsp));

    // R5
    first_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (hit && !locked) |=> (locked && cur_off == $past(hit_off)));

    // R6
    hold_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (hit && locked && !frm_mode && !frm_enable && hit_off != cur_off)
        |=> ($stable(cur_off) && nsp_r));

    // R8
    realign_all_chk: assert property (@(posedge clk) disable iff (rst)
        (hit && !frm_mode && frm_enable) |=> (cur_off == $past(hit_off) && !nsp_r));

    // R9
    first_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (hit && locked && frm_mode && !nsp_r && hit_off != cur_off)
        |=> ($stable(cur_off) && nsp_r));

    // R9
    second_move_chk: assert property (@(posedge clk) disable iff (rst)
        (hit && locked && frm_mode && nsp_r && hit_off != cur_off)
        |=> (cur_off == $past(hit_off) && !nsp_r));

    // R7
    on_boundary_chk: assert property (@(posedge clk) disable iff (rst)
        (hit && locked && hit_off == cur_off) |=> !nsp_r);
endmodule

bind trs_framer trs_framer_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .frm_mode   (frm_mode),
    .frm_enable (frm_enable),
    .trs_stb    (trs_stb),
    .h_flag     (h_flag),
    .v_flag     (v_flag),
    .f_flag     (f_flag),
    .nsp        (nsp),
    .hit        (hit),
    .hit_off    (hit_off),
    .cur_off    (cur_off),
    .locked     (locked),
    .nsp_r      (nsp_r)
);

// File: tb/trs_framer_bench.sv
module trs_framer_bench;
    localparam int W     = 10;
    localparam int NTRS  = 7;
    localparam int SLOT0 = 20;
    localparam int GAP   = 40;
    localparam int L     = SLOT0 + GAP * NTRS + 10;
    localparam int NB    = W * (L + 10);

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] raw_in = '0;
    logic         frm_mode = 1'b0;
    logic         frm_enable = 1'b0;
    logic [W-1:0] word_out;
    logic         trs_stb, h_flag, v_flag, f_flag, nsp;

    trs_framer u_trs_framer (
        .clk(clk), .rst(rst), .raw_in(raw_in), .frm_mode(frm_mode),
        .frm_enable(frm_enable), .word_out(word_out), .trs_stb(trs_stb),
        .h_flag(h_flag), .v_flag(v_flag), .f_flag(f_flag), .nsp(nsp)
    );

    always #10 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;

    logic         stream_bits [NB];
    int           t_off  [NTRS];
    logic [W-1:0] t_stat [NTRS];
    logic [W-1:0] e_word [L+4];
    logic         e_stb  [L+4];
    logic         e_nsp  [L+4];
    logic [2:0]   e_fvh  [L+4];

    function automatic logic [W-1:0] bits_at(int base);
        logic [W-1:0] r;
        for (int b = 0; b < W; b++) begin
            int idx = base + b;
            if (idx >= 0 && idx < NB) r[b] = stream_bits[idx];
            else r[b] = idx[0];
        end
        return r;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic put_word(int p, logic [W-1:0] w);
        for (int b = 0; b < W; b++) stream_bits[p + b] = w[b];
    endtask

    task automatic build(int a);
        int bo = (a + 3) % W;
        int xo = (a + 6) % W;
        for (int i = 0; i < NB; i++) stream_bits[i] = i[0];
        t_off[0] = a;  t_off[1] = a;  t_off[2] = bo; t_off[3] = bo;
        t_off[4] = xo; t_off[5] = a;  t_off[6] = a;
        for (int i = 0; i < NTRS; i++) begin
            int p = W * (SLOT0 + GAP * i) + t_off[i];
            // bit 9 = 1 marks a valid status word; bits 8,7,6 = F,V,H
            t_stat[i] = 10'h200 | W'(((i + 1) % 8) << 6) | W'((i * 5) % 64);
            if (i == 4) t_stat[i] = 10'h1C5;
            put_word(p,          10'h3FF);
            put_word(p + W,      10'h000);
            put_word(p + 2 * W,  10'h000);
            put_word(p + 3 * W,  t_stat[i]);
        end
    endtask

    task automatic model(logic mode, logic en);
        int  off = 0;
        logic lk = 1'b0;
        logic ns = 1'b0;
        logic [2:0] fv = 3'b000;
        for (int c = 0; c < 2; c++) begin
            e_word[c] = '0; e_stb[c] = 1'b0; e_nsp[c] = 1'b0; e_fvh[c] = 3'b000;
        end
        for (int q = 0; q < L + 2; q++) begin
            int c = q + 2;
            logic det = 1'b0;
            int k = 0;
            logic [W-1:0] st = '0;
            e_word[c] = bits_at(W * (q - 2) + off);
            for (int i = 0; i < NTRS; i++) begin
                if (t_stat[i][9] && (SLOT0 + GAP * i + 5 == q)) begin
                    det = 1'b1; k = t_off[i]; st = t_stat[i];
                end
            end
            if (det) begin
                if (!lk) begin
                    off = k; lk = 1'b1; ns = 1'b0;
                end else if (k == off) begin
                    ns = 1'b0;
                end else if (mode) begin
                    if (ns) begin off = k; ns = 1'b0; end
                    else ns = 1'b1;
                end else if (en) begin
                    off = k; ns = 1'b0;
                end else begin
                    ns = 1'b1;
                end
                fv = {st[8], st[7], st[6]};
            end
            e_stb[c] = det; e_nsp[c] = ns; e_fvh[c] = fv;
        end
    endtask

    task automatic run_phase(logic mode, logic en, int a);
        string pol_tag;
        int t0 = SLOT0 + 7;
        int t1 = SLOT0 + GAP + 7;
        int tx = SLOT0 + GAP * 4 + 7;
        pol_tag = mode ? "R9" : (en ? "R8" : "R6");
        build(a);
        model(mode, en);
        @(negedge clk);
        rst = 1'b1; frm_mode = mode; frm_enable = en; raw_in = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int c = 0; c < L + 4; c++) begin
            if (c == 0) begin
                check("R1 word_out", 32'(word_out), 32'(0));
                check("R1 trs_stb", 32'(trs_stb), 32'(0));
                check("R1 nsp", 32'(nsp), 32'(0));
                check("R1 flags", 32'({f_flag, v_flag, h_flag}), 32'(0));
            end else begin
                if (c >= 4) begin
                    if (c <= t0) check("R4 word", 32'(word_out), 32'(e_word[c]));
                    else if (c <= t1) check("R5 word", 32'(word_out), 32'(e_word[c]));
                    else check({pol_tag, " word"}, 32'(word_out), 32'(e_word[c]));
                end
                if (c == tx) check("R3 strobe", 32'(trs_stb), 32'(0));
                else check("R2 strobe", 32'(trs_stb), 32'(e_stb[c]));
                check({pol_tag, " R7 R11 nsp"}, 32'(nsp), 32'(e_nsp[c]));
                check("R10 flags", 32'({f_flag, v_flag, h_flag}), 32'(e_fvh[c]));
            end
            raw_in = bits_at(W * c);
            @(negedge clk);
        end
    endtask

    initial begin
        for (int m = 0; m < 2; m++)
            for (int e = 0; e < 2; e++)
                for (int a = 0; a < W; a++)
                    run_phase(m[0], e[0], a);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule